// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the memory address for a single-register load or store, and the new value for the base register when the base is updated. It takes a base value and an offset. The offset is either a zero-extended immediate, a plain index register, or an index register that first passes through a barrel shifter. The offset is added to or subtracted from the base. The indexing mode then chooses which value goes out as the access address and which value is offered for write-back.

The block sits between operand fetch and the memory port of a pipeline. A valid strobe captures one request. One cycle later the registered result appears: address, write-back enable and value, an access size code, a signed-load indication and a misalignment flag. Decoding, the register file and alignment of loaded data belong to neighbouring blocks.

Top module: `ls_addr_gen`

## Requirements
- R1: Reset clears every output to zero. A request presented with `in_valid` high produces its results, with `out_valid` high, in the following cycle. A cycle with `in_valid` low drops `out_valid` and leaves every data output unchanged.
- R2: `off_kind` selects the offset: 0 = immediate zero-extended to 32 bits, 1 = index register used as is, 2 = index register after the shifter, 3 = treated as immediate.
- R3: The shifter applies `shift_type` 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right, by `shift_amt` (0 to 31). An amount of 0 passes the index unchanged.
- R4: `off_sub` = 1 subtracts the offset from the base and 0 adds it. The result wraps modulo 2^32.
- R5: With `pre_index` = 1 and `base_update` = 0, the access address is base ± offset and `wb_en` is 0.
- R6: With `pre_index` = 1 and `base_update` = 1, the access address is base ± offset, `wb_en` is 1 and `wb_value` equals the access address.
- R7: With `pre_index` = 0 (post-indexed), the access address is the unmodified base, `wb_en` is 1 whatever `base_update` is, and `wb_value` is base ± offset.
- R8: `acc_size` 0 = byte, 1 = halfword, 2 or 3 = word. The size is reported as `size_code` 0 = byte, 1 = halfword, 2 = word. `signed_ld` is `load_signed` for byte and halfword and 0 for word.
- R9: `misaligned` is 1 for a halfword whose address has bit 0 set and for a word whose address has bit 1 or bit 0 set. It is always 0 for a byte.
- R10: `shift_type` and `shift_amt` have no effect when `off_kind` is not 2. `idx_val` has no effect when `off_kind` is 0 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| base_val | input | 32 | Base register value |
| imm_off | input | 12 | Unsigned immediate offset |
| idx_val | input | 32 | Index register value |
| shift_type | input | 2 | Shift kind for the scaled offset |
| shift_amt | input | 5 | Shift distance |
| off_sub | input | 1 | 1 subtracts the offset, 0 adds it |
| off_kind | input | 2 | Offset source select |
| pre_index | input | 1 | 1 pre-indexed, 0 post-indexed |
| base_update | input | 1 | Base write-back request in pre-indexed mode |
| acc_size | input | 2 | Access size |
| load_signed | input | 1 | Sign-extending load request |
| out_valid | output | 1 | Result valid, one cycle after the request |
| acc_addr | output | 32 | Memory access address |
| wb_en | output | 1 | Base register write-back enable |
| wb_value | output | 32 | New base register value |
| size_code | output | 2 | Reported access size |
| signed_ld | output | 1 | Sign-extension needed on the loaded value |
| misaligned | output | 1 | Address not aligned to the access size |

## Verification
A fault in the offset path shows up as a wrong `acc_addr` or `wb_value` in the cycle after the strobe. For post-indexed requests it shows only in `wb_value`, because the address is then the bare base. A wrong mode decision shows up at once, either as a write-back enable that disagrees with the indexing flags or as the two 32-bit outputs being swapped. Stale output registers show up when a cycle with no request alters the data outputs. The tests therefore use distinct base and offset values in every mode, so that any swap or leak changes an observed port.

// File: rtl/ls_agu_pkg.sv
package ls_agu_pkg;

    localparam int AGU_DW    = 32;
    localparam int AGU_IMM_W = 12;

    typedef enum logic [1:0] {
        OFS_IMM    = 2'd0,
        OFS_REG    = 2'd1,
        OFS_SCALED = 2'd2,
        OFS_ALTIMM = 2'd3
    } ofs_kind_e;

    typedef enum logic [1:0] {
        SHK_LSL = 2'd0,
        SHK_LSR = 2'd1,
        SHK_ASR = 2'd2,
        SHK_ROR = 2'd3
    } shk_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WALT = 2'd3
    } acc_sz_e;

    typedef struct packed {
        logic pre;
        logic upd;
        logic sub;
    } idx_ctrl_t;

    // Size code reported to the memory side; the spare encoding folds onto word.
    function automatic logic [1:0] norm_size(input acc_sz_e s);
        return (s == SZ_BYTE) ? 2'd0 : (s == SZ_HALF) ? 2'd1 : 2'd2;
    endfunction

endpackage

// File: rtl/ls_agu_shifter.sv
module ls_agu_shifter
    import ls_agu_pkg::*;
#(
    parameter int DW   = AGU_DW,
    localparam int SH_W = $clog2(DW)
) (
    input  logic [DW-1:0]   val_i,
    input  shk_e            kind_i,
    input  logic [SH_W-1:0] amt_i,
    output logic [DW-1:0]   val_o
);
    logic [DW-1:0] rot;

    always_comb begin
        if (amt_i == '0) begin
            rot = val_i;
        end else begin
            rot = (val_i >> amt_i) | (val_i << (DW - int'(amt_i)));
        end
    end

    always_comb begin
        unique case (kind_i)
            SHK_LSL: val_o = val_i << amt_i;
            SHK_LSR: val_o = val_i >> amt_i;
            SHK_ASR: val_o = $unsigned($signed(val_i) >>> amt_i);
            default: val_o = rot;
        endcase
    end
endmodule

// File: rtl/ls_agu_offset.sv
module ls_agu_offset
    import ls_agu_pkg::*;
#(
    parameter int DW    = AGU_DW,
    parameter int IMM_W = AGU_IMM_W,
    localparam int SH_W = $clog2(DW)
) (
    input  logic [IMM_W-1:0] imm_i,
    input  logic [DW-1:0]    idx_i,
    input  shk_e             shk_i,
    input  logic [SH_W-1:0]  amt_i,
    input  ofs_kind_e        kind_i,
    output logic [DW-1:0]    ofs_o
);
    logic [DW-1:0] imm_ext;
    logic [DW-1:0] idx_shifted;

    generate
        if (DW > IMM_W) begin : g_zext
            assign imm_ext = {{(DW-IMM_W){1'b0}}, imm_i};
        end else begin : g_trunc
            assign imm_ext = imm_i[DW-1:0];
        end
    endgenerate

    ls_agu_shifter #(.DW(DW)) u_shift (
        .val_i  (idx_i),
        .kind_i (shk_i),
        .amt_i  (amt_i),
        .val_o  (idx_shifted)
    );

    always_comb begin
        unique case (kind_i)
            OFS_REG:    ofs_o = idx_i;
            OFS_SCALED: ofs_o = idx_shifted;
            default:    ofs_o = imm_ext;
        endcase
    end
endmodule

// File: rtl/ls_agu_size_chk.sv
module ls_agu_size_chk
    import ls_agu_pkg::*;
(
    input  acc_sz_e    size_i,
    input  logic       sgn_i,
    input  logic [1:0] addr_lo_i,
    output logic [1:0] code_o,
    output logic       sgn_o,
    output logic       mis_o
);
    always_comb begin
        code_o = norm_size(size_i);
        sgn_o  = sgn_i && (code_o != 2'd2);
        unique case (code_o)
            2'd0:    mis_o = 1'b0;
            2'd1:    mis_o = addr_lo_i[0];
            default: mis_o = |addr_lo_i;
        endcase
    end
endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
    import ls_agu_pkg::*;
#(
    parameter int DW    = AGU_DW,
    parameter int IMM_W = AGU_IMM_W,
    localparam int SH_W = $clog2(DW)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [DW-1:0]    base_val,
    input  logic [IMM_W-1:0] imm_off,
    input  logic [DW-1:0]    idx_val,
    input  logic [1:0]       shift_type,
    input  logic [SH_W-1:0]  shift_amt,
    input  logic             off_sub,
    input  logic [1:0]       off_kind,
    input  logic             pre_index,
    input  logic             base_update,
    input  logic [1:0]       acc_size,
    input  logic             load_signed,
    output logic             out_valid,
    output logic [DW-1:0]    acc_addr,
    output logic             wb_en,
    output logic [DW-1:0]    wb_value,
    output logic [1:0]       size_code,
    output logic             signed_ld,
    output logic             misaligned
);
    idx_ctrl_t     ctl;
    logic [DW-1:0] ofs;
    logic [DW-1:0] moved;
    logic [DW-1:0] nxt_addr;
    logic          nxt_wb;
    logic [1:0]    nxt_code;
    logic          nxt_sgn;
    logic          nxt_mis;

    assign ctl = '{pre: pre_index, upd: base_update, sub: off_sub};

    ls_agu_offset #(.DW(DW), .IMM_W(IMM_W)) u_ofs (
        .imm_i  (imm_off),
        .idx_i  (idx_val),
        .shk_i  (shk_e'(shift_type)),
        .amt_i  (shift_amt),
        .kind_i (ofs_kind_e'(off_kind)),
        .ofs_o  (ofs)
    );

    // One adder serves both the pre-indexed address and the new base.
    always_comb begin
        moved    = ctl.sub ? (base_val - ofs) : (base_val + ofs);
        nxt_addr = ctl.pre ? moved : base_val;
        nxt_wb   = !ctl.pre || ctl.upd;
    end

    ls_agu_size_chk u_size (
        .size_i    (acc_sz_e'(acc_size)),
        .sgn_i     (load_signed),
        .addr_lo_i (nxt_addr[1:0]),
        .code_o    (nxt_code),
        .sgn_o     (nxt_sgn),
        .mis_o     (nxt_mis)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            acc_addr   <= '0;
            wb_en      <= 1'b0;
            wb_value   <= '0;
            size_code  <= 2'd0;
            signed_ld  <= 1'b0;
            misaligned <= 1'b0;
        end else if (in_valid) begin
            out_valid  <= 1'b1;
            acc_addr   <= nxt_addr;
            wb_en      <= nxt_wb;
            wb_value   <= moved;
            size_code  <= nxt_code;
            signed_ld  <= nxt_sgn;
            misaligned <= nxt_mis;
        end else begin
            out_valid  <= 1'b0;
        end
    end
endmodule

// File: rtl/ls_addr_gen_chk.sv
module ls_addr_gen_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [DW-1:0] base_val,
    input logic          pre_index,
    input logic          base_update,
    input logic [1:0]    acc_size,
    input logic          out_valid,
    input logic [DW-1:0] acc_addr,
    input logic          wb_en,
    input logic [DW-1:0] wb_value,
    input logic [1:0]    size_code,
    input logic          misaligned
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(acc_addr) && $stable(wb_value) && $stable(wb_en))); // R1
    AST_PRE_NO_WB: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pre_index && !base_update) |=> !wb_en); // R5
    AST_PRE_WB_SAME: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pre_index && base_update) |=> (wb_en && wb_value == acc_addr)); // R6
    AST_POST_BASE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !pre_index) |=> (wb_en && acc_addr == $past(base_val))); // R7
    AST_BYTE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (in_valid && acc_size == 2'd0) |=> (size_code == 2'd0 && !misaligned)); // R9
    AST_WORD_MISALIGN: assert property (@(posedge clk) disable iff (rst)
        (out_valid && size_code == 2'd2) |-> (misaligned == (acc_addr[1:0] != 2'b00))); // R9
endmodule

bind ls_addr_gen ls_addr_gen_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .base_val    (base_val),
    .pre_index   (pre_index),
    .base_update (base_update),
    .acc_size    (acc_size),
    .out_valid   (out_valid),
    .acc_addr    (acc_addr),
    .wb_en       (wb_en),
    .wb_value    (wb_value),
    .size_code   (size_code),
    .misaligned  (misaligned)
);

// File: tb/ls_addr_gen_bench.sv
module ls_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] base_val;
    logic [11:0] imm_off;
    logic [31:0] idx_val;
    logic [1:0]  shift_type;
    logic [4:0]  shift_amt;
    logic        off_sub;
    logic [1:0]  off_kind;
    logic        pre_index;
    logic        base_update;
    logic [1:0]  acc_size;
    logic        load_signed;
    logic        out_valid;
    logic [31:0] acc_addr;
    logic        wb_en;
    logic [31:0] wb_value;
    logic [1:0]  size_code;
    logic        signed_ld;
    logic        misaligned;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ls_addr_gen u_ls_addr_gen (
        .clk(clk), .rst(rst), .in_valid(in_valid), .base_val(base_val),
        .imm_off(imm_off), .idx_val(idx_val), .shift_type(shift_type),
        .shift_amt(shift_amt), .off_sub(off_sub), .off_kind(off_kind),
        .pre_index(pre_index), .base_update(base_update), .acc_size(acc_size),
        .load_signed(load_signed), .out_valid(out_valid), .acc_addr(acc_addr),
        .wb_en(wb_en), .wb_value(wb_value), .size_code(size_code),
        .signed_ld(signed_ld), .misaligned(misaligned)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Drive one request at a falling edge; results are checked at the next falling edge.
    task automatic issue(input logic [31:0] b, input logic [11:0] im, input logic [31:0] ix,
                         input logic [1:0] st, input logic [4:0] sa, input logic sb,
                         input logic [1:0] ok, input logic pr, input logic up,
                         input logic [1:0] sz, input logic sg);
        @(negedge clk);
        base_val = b; imm_off = im; idx_val = ix; shift_type = st; shift_amt = sa;
        off_sub = sb; off_kind = ok; pre_index = pr; base_update = up;
        acc_size = sz; load_signed = sg; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_ab(input string req, input logic [31:0] a, input logic w,
                             input logic [31:0] wv);
        chk({req, " valid"}, {31'd0, out_valid}, 32'd1);
        chk({req, " addr"}, acc_addr, a);
        chk({req, " wb_en"}, {31'd0, wb_en}, {31'd0, w});
        if (w) chk({req, " wb_value"}, wb_value, wv);
    endtask

    task automatic t_reset;
        chk("R1 reset valid", {31'd0, out_valid}, 32'd0);
        chk("R1 reset addr", acc_addr, 32'd0);
        chk("R1 reset wb", {31'd0, wb_en}, 32'd0);
        chk("R1 reset wbv", wb_value, 32'd0);
    endtask

    task automatic t_offset_kinds;
        issue(32'h200, 12'd12, 32'h5555, 2'd0, 5'd4, 1'b0, 2'd0, 1'b1, 1'b0, 2'd2, 1'b0);
        expect_ab("R2 R5 imm", 32'h20C, 1'b0, 32'h0);
        issue(32'h1000, 12'd7, 32'h30, 2'd0, 5'd4, 1'b0, 2'd1, 1'b1, 1'b0, 2'd2, 1'b0);
        expect_ab("R2 R10 reg ignores shift", 32'h1030, 1'b0, 32'h0);
        issue(32'h1000, 12'h0FF, 32'hABCD, 2'd1, 5'd3, 1'b0, 2'd3, 1'b1, 1'b0, 2'd0, 1'b0);
        expect_ab("R2 R10 kind3 as imm", 32'h10FF, 1'b0, 32'h0);
        issue(32'h1000, 12'hFFF, 32'h0, 2'd0, 5'd0, 1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b0);
        expect_ab("R2 imm zero ext", 32'h1FFF, 1'b0, 32'h0);
    endtask

    task automatic t_shifts;
        issue(32'h100, 12'd0, 32'd3, 2'd0, 5'd2, 1'b0, 2'd2, 1'b1, 1'b0, 2'd2, 1'b0);
        expect_ab("R3 lsl2", 32'h10C, 1'b0, 32'h0);
        issue(32'h100, 12'd0, 32'd3, 2'd0, 5'd3, 1'b0, 2'd2, 1'b1, 1'b0, 2'd2, 1'b0);
        expect_ab("R3 lsl3", 32'h118, 1'b0, 32'h0);
        issue(32'h0, 12'd0, 32'h8000_0000, 2'd1, 5'd4, 1'b0, 2'd2, 1'b1, 1'b0, 2'd2, 1'b0);
        expect_ab("R3 lsr", 32'h0800_0000, 1'b0, 32'h0);
        issue(32'h0, 12'd0, 32'h8000_0000, 2'd2, 5'd4, 1'b0, 2'd2, 1'b1, 1'b0, 2'd2, 1'b0);
        expect_ab("R3 asr", 32'hF800_0000, 1'b0, 32'h0);
        issue(32'h0, 12'd0, 32'h0000_000F, 2'd3, 5'd4, 1'b0, 2'd2, 1'b1, 1'b0, 2'd2, 1'b0);
        expect_ab("R3 ror", 32'hF000_0000, 1'b0, 32'h0);
        issue(32'h4, 12'd0, 32'h1234_5678, 2'd3, 5'd0, 1'b0, 2'd2, 1'b1, 1'b0, 2'd2, 1'b0);
        expect_ab("R3 amt0", 32'h1234_567C, 1'b0, 32'h0);
    endtask

    task automatic t_sign_wrap;
        issue(32'h10, 12'h20, 32'h0, 2'd0, 5'd0, 1'b1, 2'd0, 1'b1, 1'b0, 2'd2, 1'b0);
        expect_ab("R4 sub wrap", 32'hFFFF_FFF0, 1'b0, 32'h0);
        issue(32'hFFFF_FFFC, 12'd8, 32'h0, 2'd0, 5'd0, 1'b0, 2'd0, 1'b1, 1'b0, 2'd2, 1'b0);
        expect_ab("R4 add wrap", 32'h4, 1'b0, 32'h0);
        issue(32'h100, 12'd0, 32'd2, 2'd0, 5'd2, 1'b1, 2'd2, 1'b1, 1'b0, 2'd2, 1'b0);
        expect_ab("R4 sub scaled", 32'hF8, 1'b0, 32'h0);
    endtask

    task automatic t_modes;
        issue(32'h400, 12'd12, 32'h0, 2'd0, 5'd0, 1'b0, 2'd0, 1'b1, 1'b1, 2'd2, 1'b0);
        expect_ab("R6 pre update", 32'h40C, 1'b1, 32'h40C);
        issue(32'h800, 12'd4, 32'h0, 2'd0, 5'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd2, 1'b0);
        expect_ab("R7 post imm", 32'h800, 1'b1, 32'h804);
        issue(32'h800, 12'd0, 32'd5, 2'd0, 5'd3, 1'b1, 2'd2, 1'b0, 1'b1, 2'd2, 1'b0);
        expect_ab("R7 post scaled sub", 32'h800, 1'b1, 32'h7D8);
    endtask

    task automatic t_sizes;
        issue(32'h1001, 12'd0, 32'h0, 2'd0, 5'd0, 1'b0, 2'd0, 1'b1, 1'b0, 2'd1, 1'b1);
        chk("R8 half code", {30'd0, size_code}, 32'd1);
        chk("R8 half signed", {31'd0, signed_ld}, 32'd1);
        chk("R9 half odd", {31'd0, misaligned}, 32'd1);
        issue(32'h1002, 12'd0, 32'h0, 2'd0, 5'd0, 1'b0, 2'd0, 1'b1, 1'b0, 2'd2, 1'b1);
        chk("R8 word code", {30'd0, size_code}, 32'd2);
        chk("R8 word unsigned", {31'd0, signed_ld}, 32'd0);
        chk("R9 word at 2", {31'd0, misaligned}, 32'd1);
        issue(32'h1003, 12'd0, 32'h0, 2'd0, 5'd0, 1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b1);
        chk("R8 byte code", {30'd0, size_code}, 32'd0);
        chk("R8 byte signed", {31'd0, signed_ld}, 32'd1);
        chk("R9 byte never", {31'd0, misaligned}, 32'd0);
        issue(32'h1002, 12'd0, 32'h0, 2'd0, 5'd0, 1'b0, 2'd0, 1'b1, 1'b0, 2'd1, 1'b0);
        chk("R9 half even", {31'd0, misaligned}, 32'd0);
        chk("R8 half unsigned", {31'd0, signed_ld}, 32'd0);
        issue(32'h1008, 12'd0, 32'h0, 2'd0, 5'd0, 1'b0, 2'd0, 1'b1, 1'b0, 2'd3, 1'b0);
        chk("R8 size3 as word", {30'd0, size_code}, 32'd2);
        chk("R9 word aligned", {31'd0, misaligned}, 32'd0);
        // Post-indexed: the flag follows the base, not the updated value.
        issue(32'h2000, 12'd1, 32'h0, 2'd0, 5'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd2, 1'b0);
        chk("R9 R7 post uses base", {31'd0, misaligned}, 32'd0);
    endtask

    task automatic t_idle_hold;
        issue(32'h3000, 12'd16, 32'h0, 2'd0, 5'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd2, 1'b0);
        base_val = 32'hDEAD_0000; imm_off = 12'd1; pre_index = 1'b1;
        @(negedge clk);
        chk("R1 idle valid low", {31'd0, out_valid}, 32'd0);
        chk("R1 idle addr hold", acc_addr, 32'h3000);
        chk("R1 idle wbv hold", wb_value, 32'h3010);
        chk("R1 idle wb hold", {31'd0, wb_en}, 32'd1);
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; base_val = '0; imm_off = '0; idx_val = '0;
        shift_type = '0; shift_amt = '0; off_sub = 1'b0; off_kind = '0;
        pre_index = 1'b1; base_update = 1'b0; acc_size = '0; load_signed = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_offset_kinds();
        t_shifts();
        t_sign_wrap();
        t_modes();
        t_sizes();
        t_idle_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog got=%0d exp=%0d", 0, 1);
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule